// File: doc/BRIEF.md
# GPIO Output Set/Clear Register Bank

This block holds the output state of several 32-bit general-purpose I/O ports behind a simple word-wide register bus. Each port keeps one output latch. Software raises pins by writing ones to a set register and lowers them by writing ones to a clear register. Zero bits in either write leave the pins as they are, so a single store can change some pins without a read-modify-write.

Every port also has a mask register and a pin-mode field for each pin. A mask bit of 1 shields its pin from set and clear writes. The mode field marks a pin as GPIO output, GPIO input or alternate function. A clear write only acts on pins in GPIO output mode. The per-port direction vector is high exactly for pins in GPIO output mode.

The bus is word-addressed: `bus_addr[1:0]` must be zero, and byte strobes select lanes. Writing the set register with strobe `0001` is the byte alias for pins 0 to 7. Strobe `0010` is the byte alias for pins 8 to 15, with its data in `bus_wdata[15:8]`. Strobe `0011` is the lower half-word alias for pins 0 to 15. Ports sit 0x20 bytes apart. Within a port the registers are:

| Offset | Register |
|---|---|
| 0x00 | set |
| 0x04 | clear |
| 0x08 | mask |
| 0x0C | mode of pins 0 to 15 |
| 0x10 | mode of pins 16 to 31 |

Top module: `gpio_sc_bank`

## Requirements
- R1: While `rst_n` is low, all output latches, masks and mode fields are 0. Pin outputs and direction bits read 0, and mode 00 means GPIO input.
- R2: A write to the set register (offset 0x00) forces every unmasked pin whose data bit is 1 to 1 in the latch. Bits whose data is 0 keep their value. The new value appears on `pin_out` after the write's clock edge.
- R3: A write to the clear register (offset 0x04) forces to 0 every unmasked, GPIO-output pin whose data bit is 1. Zero data bits have no effect, and set and clear share the one latch.
- R4: A clear write leaves untouched any pin in GPIO input mode (00) or in an alternate mode (10 or 11).
- R5: A read of the clear register returns 0.
- R6: The mask register (offset 0x08) reads back as written. A mask bit of 1 blocks set and clear writes to its pin, and a mask bit of 0 lets them through.
- R7: A set write with strobe `0001` changes only pins 7..0, using `bus_wdata[7:0]`. A set write with strobe `0010` changes only pins 15..8, using `bus_wdata[15:8]`. No other pin changes.
- R8: A set write with strobe `0011` changes only pins 15..0, and pins 31..16 keep their state.
- R9: Pin n's mode is the 2-bit field at bits 2n+1:2n of offset 0x0C for n < 16, and at bits 2(n-16)+1:2(n-16) of offset 0x10 for n ≥ 16. The value 01 means GPIO output. `pin_oe` bit n is 1 exactly when the mode is 01, and the mode registers read back as written.
- R10: A read of the set register returns the output latch. `bus_rdata` is registered and valid in the cycle after `bus_rd` is sampled.
- R11: Port p occupies byte addresses 0x20·p to 0x20·p+0x13. Ports are independent. A write to a port index of NUM_PORTS or more has no effect, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| pin_out | output | NUM_PORTS*32 | Output latch of every port, port p at bits 32p+31:32p |
| pin_oe | output | NUM_PORTS*32 | Direction per pin, 1 for GPIO output mode |

## Verification
A write changes the latch, mask or mode at the clock edge where `bus_wr` is sampled. So `pin_out` and `pin_oe` are due at the next falling edge, and the bench checks them there. A read returns data one cycle after `bus_rd`. The bench raises the strobe at a falling edge and compares `bus_rdata` at the following falling edge, which is just after the capturing edge. Because every stimulus is applied and every result sampled half a cycle away from the active edge, no check depends on the order of processes at a clock edge.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

  localparam int unsigned PORT_W  = 32;
  localparam int unsigned LANES   = PORT_W / 8;
  localparam int unsigned SPAN_LG = 5;        // 0x20 bytes per port

  localparam logic [1:0] MODE_IN  = 2'b00;
  localparam logic [1:0] MODE_OUT = 2'b01;

  typedef enum logic [2:0] {
    RS_SET     = 3'd0,
    RS_CLR     = 3'd1,
    RS_MASK    = 3'd2,
    RS_MODE_LO = 3'd3,
    RS_MODE_HI = 3'd4
  } reg_sel_e;

  // expand byte strobes into a per-bit lane mask
  function automatic logic [PORT_W-1:0] lane_bits(input logic [LANES-1:0] be);
    logic [PORT_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[8*i +: 8] = {8{be[i]}};
    return r;
  endfunction

  function automatic logic [PORT_W-1:0] apply_set(input logic [PORT_W-1:0] cur,
                                                  input logic [PORT_W-1:0] ones,
                                                  input logic [PORT_W-1:0] blk);
    return cur | (ones & ~blk);
  endfunction

  function automatic logic [PORT_W-1:0] apply_clr(input logic [PORT_W-1:0] cur,
                                                  input logic [PORT_W-1:0] ones,
                                                  input logic [PORT_W-1:0] blk,
                                                  input logic [PORT_W-1:0] outp);
    return cur & ~(ones & ~blk & outp);
  endfunction

  function automatic logic [PORT_W-1:0] out_pins(input logic [PORT_W-1:0] lo,
                                                 input logic [PORT_W-1:0] hi);
    logic [PORT_W-1:0] r;
    for (int i = 0; i < PORT_W/2; i++) begin
      r[i]            = (lo[2*i +: 2] == MODE_OUT);
      r[i + PORT_W/2] = (hi[2*i +: 2] == MODE_OUT);
    end
    return r;
  endfunction

  function automatic logic [PORT_W-1:0] merge_lanes(input logic [PORT_W-1:0] cur,
                                                    input logic [PORT_W-1:0] wd,
                                                    input logic [PORT_W-1:0] lanes);
    return (cur & ~lanes) | (wd & lanes);
  endfunction

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
  import gpio_sc_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_PORTS-1:0] port_sel,
  output reg_sel_e             reg_sel
);
  localparam int unsigned PIDX_W = ADDR_W - SPAN_LG;

  logic [PIDX_W-1:0] port_idx;
  logic [2:0]        reg_idx;
  logic              reg_ok;

  assign port_idx = addr[ADDR_W-1:SPAN_LG];
  assign reg_idx  = addr[SPAN_LG-1:2];
  assign reg_ok   = (reg_idx <= 3'd4) && (addr[1:0] == 2'b00);
  assign reg_sel  = reg_sel_e'(reg_idx);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sel
    assign port_sel[p] = reg_ok && (port_idx == PIDX_W'(p));
  end

  always_comb begin
    assert ($onehot0(port_sel)) else $error("AST_ONE_PORT");   // R11
  end
endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port
  import gpio_sc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          reg_sel,
  input  logic [PORT_W-1:0] wdata,
  input  logic [LANES-1:0]  be,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] mask_q,
  output logic [PORT_W-1:0] mode_lo_q,
  output logic [PORT_W-1:0] mode_hi_q,
  output logic [PORT_W-1:0] out_en
);
  logic [PORT_W-1:0] lanes, ones, latch_d;
  logic              set_hit, clr_hit;

  assign lanes   = lane_bits(be);
  assign ones    = wdata & lanes;
  assign set_hit = wr_en && (reg_sel == RS_SET);
  assign clr_hit = wr_en && (reg_sel == RS_CLR);
  assign out_en  = out_pins(mode_lo_q, mode_hi_q);

  always_comb begin
    latch_d = latch_q;
    if (clr_hit)      latch_d = apply_clr(latch_q, ones, mask_q, out_en);
    else if (set_hit) latch_d = apply_set(latch_q, ones, mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q   <= '0;
      mask_q    <= '0;
      mode_lo_q <= '0;
      mode_hi_q <= '0;
    end else begin
      latch_q <= latch_d;
      if (wr_en && reg_sel == RS_MASK)    mask_q    <= merge_lanes(mask_q, wdata, lanes);
      if (wr_en && reg_sel == RS_MODE_LO) mode_lo_q <= merge_lanes(mode_lo_q, wdata, lanes);
      if (wr_en && reg_sel == RS_MODE_HI) mode_hi_q <= merge_lanes(mode_hi_q, wdata, lanes);
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> (latch_q == '0 && mask_q == '0 && out_en == '0));             // R1
  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((latch_q & $past(ones & ~mask_q)) == $past(ones & ~mask_q))); // R2
  AST_CLR_OUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (((latch_q ^ $past(latch_q)) & ~$past(out_en)) == '0));      // R4
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit || clr_hit) |=> (((latch_q ^ $past(latch_q)) & $past(mask_q)) == '0)); // R6
  AST_LANE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> (((latch_q ^ $past(latch_q)) & ~$past(lanes)) == '0));       // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_hit || clr_hit) |=> $stable(latch_q));                              // R11
endmodule

// File: rtl/gpio_sc_bank.sv
module gpio_sc_bank
  import gpio_sc_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  input  logic [3:0]                  bus_be,
  output logic [31:0]                 bus_rdata,
  output logic [NUM_PORTS*PORT_W-1:0] pin_out,
  output logic [NUM_PORTS*PORT_W-1:0] pin_oe
);
  logic [NUM_PORTS-1:0] port_sel;
  reg_sel_e             reg_sel;
  logic [PORT_W-1:0]    latch_a [NUM_PORTS];
  logic [PORT_W-1:0]    mask_a  [NUM_PORTS];
  logic [PORT_W-1:0]    mlo_a   [NUM_PORTS];
  logic [PORT_W-1:0]    mhi_a   [NUM_PORTS];
  logic [PORT_W-1:0]    rd_val;
  logic                 rd_clr_hit;

  gpio_sc_decode #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .port_sel(port_sel), .reg_sel(reg_sel)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_sc_port u_port (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr && port_sel[p]), .reg_sel(reg_sel),
      .wdata(bus_wdata), .be(bus_be),
      .latch_q(latch_a[p]), .mask_q(mask_a[p]),
      .mode_lo_q(mlo_a[p]), .mode_hi_q(mhi_a[p]),
      .out_en(pin_oe[p*PORT_W +: PORT_W])
    );
    assign pin_out[p*PORT_W +: PORT_W] = latch_a[p];
  end

  always_comb begin
    rd_val = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_sel[p]) begin
        case (reg_sel)
          RS_SET:     rd_val = latch_a[p];
          RS_MASK:    rd_val = mask_a[p];
          RS_MODE_LO: rd_val = mlo_a[p];
          RS_MODE_HI: rd_val = mhi_a[p];
          default:    rd_val = '0;   // clear register is write-only
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assign rd_clr_hit = bus_rd && (|port_sel) && (reg_sel == RS_CLR);

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_hit |=> (bus_rdata == '0));                                        // R5
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !(|port_sel)) |=> (bus_rdata == '0));                          // R11
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));                                          // R10
endmodule

// File: tb/sim_gpio_sc_bank.sv
`timescale 1ns/1ps
module sim_gpio_sc_bank;
  localparam int NP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic [NP*32-1:0] pin_out, pin_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_sc_bank #(.NUM_PORTS(NP), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // vector: {is_read, addr, wdata, be, expected read, requirement number}
  localparam int NV = 35;
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 8'h0C, 32'h5555_5555, 4'hF, 32'h0, 4'd9},  // all pins output, R9
    {1'b0, 8'h10, 32'h5555_5555, 4'hF, 32'h0, 4'd9},
    {1'b0, 8'h00, 32'hF0F0_00FF, 4'hF, 32'h0, 4'd2},
    {1'b1, 8'h00, 32'h0, 4'h0, 32'hF0F0_00FF, 4'd2},  // R2 set word
    {1'b0, 8'h00, 32'h0000_0100, 4'hF, 32'h0, 4'd2},
    {1'b1, 8'h00, 32'h0, 4'h0, 32'hF0F0_01FF, 4'd2},  // R2 zeros keep
    {1'b0, 8'h04, 32'h0000_000F, 4'hF, 32'h0, 4'd3},
    {1'b1, 8'h00, 32'h0, 4'h0, 32'hF0F0_01F0, 4'd3},  // R3 clear
    {1'b1, 8'h04, 32'h0, 4'h0, 32'h0, 4'd5},          // R5 clear reads 0
    {1'b0, 8'h08, 32'h0000_00F0, 4'hF, 32'h0, 4'd6},
    {1'b0, 8'h04, 32'h0000_0FFF, 4'hF, 32'h0, 4'd6},
    {1'b1, 8'h00, 32'h0, 4'h0, 32'hF0F0_00F0, 4'd6},  // R6 mask blocks clear
    {1'b0, 8'h08, 32'h0000_0003, 4'hF, 32'h0, 4'd6},
    {1'b0, 8'h00, 32'h0000_000F, 4'hF, 32'h0, 4'd6},
    {1'b1, 8'h00, 32'h0, 4'h0, 32'hF0F0_00FC, 4'd6},  // R6 mask blocks set
    {1'b0, 8'h08, 32'h0, 4'hF, 32'h0, 4'd6},
    {1'b0, 8'h00, 32'hFFFF_FF01, 4'h1, 32'h0, 4'd7},
    {1'b1, 8'h00, 32'h0, 4'h0, 32'hF0F0_00FD, 4'd7},  // R7 byte 0
    {1'b0, 8'h00, 32'hFFFF_0A00, 4'h2, 32'h0, 4'd7},
    {1'b1, 8'h00, 32'h0, 4'h0, 32'hF0F0_0AFD, 4'd7},  // R7 byte 1
    {1'b0, 8'h00, 32'hFFFF_1002, 4'h3, 32'h0, 4'd8},
    {1'b1, 8'h00, 32'h0, 4'h0, 32'hF0F0_1AFF, 4'd8},  // R8 half-word
    {1'b0, 8'h0C, 32'h5555_5578, 4'hF, 32'h0, 4'd4},  // pin0 in, pin1/2 alt
    {1'b0, 8'h04, 32'h0000_000F, 4'hF, 32'h0, 4'd4},
    {1'b1, 8'h00, 32'h0, 4'h0, 32'hF0F0_1AF7, 4'd4},  // R4 only pin3 cleared
    {1'b1, 8'h0C, 32'h0, 4'h0, 32'h5555_5578, 4'd9},  // R9 readback
    {1'b0, 8'h20, 32'h1234_5678, 4'hF, 32'h0, 4'd11},
    {1'b1, 8'h20, 32'h0, 4'h0, 32'h1234_5678, 4'd11}, // R11 port 1
    {1'b1, 8'h00, 32'h0, 4'h0, 32'hF0F0_1AF7, 4'd11}, // R11 port 0 intact
    {1'b0, 8'h24, 32'hFFFF_FFFF, 4'hF, 32'h0, 4'd4},
    {1'b1, 8'h20, 32'h0, 4'h0, 32'h1234_5678, 4'd4},  // R4 input pins kept
    {1'b0, 8'h40, 32'hFFFF_FFFF, 4'hF, 32'h0, 4'd11},
    {1'b1, 8'h40, 32'h0, 4'h0, 32'h0, 4'd11},         // R11 out of range
    {1'b1, 8'h08, 32'h0, 4'h0, 32'h0, 4'd6},
    {1'b1, 8'h24, 32'h0, 4'h0, 32'h0, 4'd5}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    chk("R1 pin_out in reset", pin_out, '0);
    chk("R1 pin_oe in reset", pin_oe, '0);
    rst_n = 1'b1;
    bus_read(8'h00, rd); chk("R1 latch after reset", 64'(rd), 64'h0);
    bus_read(8'h08, rd); chk("R1 mask after reset", 64'(rd), 64'h0);

    for (int i = 0; i < NV; i++) begin
      logic [80:0] v;
      v = VEC[i];
      if (v[80]) begin
        bus_read(v[79:72], rd);
        chk($sformatf("R%0d vec%0d", v[3:0], i), 64'(rd), 64'(v[35:4]));
      end else begin
        bus_write(v[79:72], v[71:40], v[39:36]);
      end
    end

    // R10: pin_out tracks latch right after the write edge
    chk("R10 pin_out port0", 64'(pin_out[31:0]), 64'hF0F0_1AF7);
    chk("R10 pin_out port1", 64'(pin_out[63:32]), 64'h1234_5678);
    // R9: pins 0..2 not output on port 0, port 1 all inputs
    chk("R9 pin_oe port0", 64'(pin_oe[31:0]), 64'hFFFF_FFF8);
    chk("R9 pin_oe port1", 64'(pin_oe[63:32]), 64'h0);
    // R2: set result visible one edge after the write
    bus_write(8'h00, 32'h0000_0100, 4'hF);
    chk("R2 pin_out after set", 64'(pin_out[31:0]), 64'hF0F0_1BF7);
    // R3: clear result visible one edge after the write
    bus_write(8'h04, 32'hF000_0000, 4'hF);
    chk("R3 pin_out after clear", 64'(pin_out[31:0]), 64'h00F0_1BF7);
    // R8: half-word with upper data does not touch pins 31..16
    bus_write(8'h00, 32'hFFFF_0000, 4'h3);
    chk("R8 upper pins kept", 64'(pin_out[31:0]), 64'h00F0_1BF7);
    // R9: high mode register controls pins 16..31
    bus_write(8'h30, 32'h0000_0001, 4'hF);
    chk("R9 port1 pin16 oe", 64'(pin_oe[63:32]), 64'h0001_0000);
    // R1: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 pin_out reset mid-run", pin_out, '0);
    chk("R1 pin_oe reset mid-run", pin_oe, '0);
    rst_n = 1'b1;
    bus_read(8'h0C, rd); chk("R1 mode after reset", 64'(rd), 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule